// File: doc/BRIEF.md
# Privilege Mode and Exception Entry Controller

This block keeps the privilege state of a small stack-based processor core. It owns the status register, which includes the supervisor flag, and two stack pointers: one for user code and one for supervisor code. Register A7 is an alias. When the core reads or writes A7, the block routes the access to whichever stack pointer the supervisor flag selects. From the same flag and the kind of bus cycle, it produces a 3-bit function code for every bus access.

The core sends one decoded request strobe per instruction. The block either grants the request or refuses it. A privileged instruction attempted at user level produces a one-cycle violation strobe and is not executed. It then starts exception entry with a fixed vector.

Exception entry can come from a trap, a violation or an external exception. It pushes the old status register first, then the program counter, and for a full frame also the processor state word. Only then does the supervisor flag rise. Each frame is kept with a 1-bit type tag. The return-from-exception request uses that tag to choose between a one-cycle short restore and a two-cycle full restore. The restored status word then decides the new privilege level.

Top module: `priv_exc_ctrl`

## Requirements
- R1: After reset the status word reads 0x2000, so the supervisor flag (bit 13) is set. A7 reads the reset stack value, the user stack pointer is zero, and `busy` is low.
- R2: A7 reads and writes go to the supervisor stack pointer while bit 13 is set, and to the user stack pointer while it is clear. The stack pointer that is not selected keeps its value.
- R3: The function code is 3'b111 whenever `busCpu` is high. Otherwise it is 3'b001 for user data, 3'b010 for user program, 3'b101 for supervisor data and 3'b110 for supervisor program.
- R4: Operation code 0 (plain) is granted at either level with a one-cycle `opGrant` pulse, and it changes no state.
- R5: At supervisor level, codes 1, 2 and 3 (stop, low-power stop, reset) and code 4 (status write) are granted. Code 4 loads `srWrData` into the status word, so its bit 13 sets the new level, and it pulses `flush` for one cycle.
- R6: At user level, codes 1 to 4 and code 6 are not executed. They leave the status word unchanged, give a one-cycle `privViol` pulse with no grant, and start exception entry with vector 8.
- R7: Code 5 (trap) is accepted at user level without a violation. It enters exception processing with vector 32 plus the 4-bit trap number.
- R8: Exception entry works in this order. In the cycle after acceptance, the status word in force before entry goes out as a push. The next cycle pushes the program counter. A full frame adds a third push with the state word. The supervisor flag rises together with the last push, when `excTaken` pulses. Every push is a supervisor data access (function code 3'b101).
- R9: Entry lowers the supervisor stack pointer by 6 for a short frame and by 10 for a full frame. A return raises it by the same amount.
- R10: A return (code 6) over a short frame takes one cycle. It restores the status word and the program counter, pulses `flush` and `opGrant`, and takes the new level from the restored bit 13.
- R11: A return over a full frame takes two cycles. The restore pulse comes in the second cycle and also carries the saved state word with `restoreFull` high.
- R12: A return at supervisor level with no saved frame is ignored. It produces no grant, no flush and no restore, and the status word keeps its value.
- R13: While `busy` is high, new operation requests are ignored.
- R14: An external exception uses `excVector`, and `excFull` picks the full frame type for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| resetSsp | input | AW | Value loaded into the supervisor stack pointer at reset |
| opValid | input | 1 | Operation request strobe |
| opKind | input | 3 | Operation code: 0 plain, 1 stop, 2 low-power stop, 3 reset, 4 status write, 5 trap, 6 return |
| trapNum | input | TRAPW | Trap number for code 5 |
| srWrData | input | SRW | New status word for code 4 |
| excReq | input | 1 | External exception request |
| excFull | input | 1 | External exception needs a full frame |
| excVector | input | VECW | Vector of the external exception |
| pcIn | input | AW | Program counter to save on entry |
| stateIn | input | DW | Processor state word to save in a full frame |
| a7WrEn | input | 1 | Write A7 |
| a7WrData | input | AW | Data for the A7 write |
| busProg | input | 1 | Current bus cycle fetches program |
| busCpu | input | 1 | Current bus cycle is a CPU-space cycle |
| srOut | output | SRW | Status word |
| sBit | output | 1 | Supervisor flag |
| a7Out | output | AW | Stack pointer currently aliased by A7 |
| fcOut | output | 3 | Function code of the current bus cycle |
| busy | output | 1 | Entry or return sequence in progress |
| opGrant | output | 1 | Operation executed (pulse) |
| privViol | output | 1 | Privilege violation (pulse) |
| flush | output | 1 | Pipeline flush after a level-changing instruction (pulse) |
| excTaken | output | 1 | Exception entry completed (pulse) |
| vectorOut | output | VECW | Vector of the last exception entered |
| pushValid | output | 1 | Frame word pushed this cycle |
| pushData | output | DW | Pushed frame word |
| restoreValid | output | 1 | Frame restored (pulse) |
| restorePc | output | AW | Restored program counter |
| restoreState | output | DW | Restored state word (full frames) |
| restoreFull | output | 1 | Restored frame was full |

## Verification
The bench uses the default parameters: 32-bit addresses and state words, a 16-bit status word with the flag at bit 13, four frame slots, a privilege vector of 8 and a trap base of 32. With a 4-bit trap number, traps 0 and 15 reach both ends of the trap vector range. The 32-bit stack pointers show the exact 6-byte and 10-byte adjustments for short and full frames. All function-code combinations are walked at both levels. Each kind of entry is followed by a return, so both the short and the full restore paths are exercised, as is a return with no saved frame.

// File: rtl/privctl_pkg.sv
package privctl_pkg;

  typedef enum logic [2:0] {
    OP_PLAIN  = 3'd0,
    OP_STOP   = 3'd1,
    OP_LPSTOP = 3'd2,
    OP_RESET  = 3'd3,
    OP_SRWR   = 3'd4,
    OP_TRAP   = 3'd5,
    OP_RTE    = 3'd6
  } opKind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_SR,
    ST_PUSH_PC,
    ST_PUSH_ST,
    ST_RTE_FULL
  } seqState_e;

  localparam logic [2:0] FC_USR_DATA = 3'b001;
  localparam logic [2:0] FC_USR_PROG = 3'b010;
  localparam logic [2:0] FC_SUP_DATA = 3'b101;
  localparam logic [2:0] FC_SUP_PROG = 3'b110;
  localparam logic [2:0] FC_CPU      = 3'b111;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic latchEntry;
    logic entryFull;
    logic pushSr;
    logic pushPc;
    logic pushSt;
    logic finishEntry;
    logic srLoad;
    logic rteShort;
    logic rteFull;
    logic a7Write;
  } ctrlStrobe_t;

endpackage

// File: rtl/privctl_seq.sv
module privctl_seq
  import privctl_pkg::*;
#(
  parameter int TRAPW     = 4,
  parameter int VECW      = 8,
  parameter int PRIV_VEC  = 8,
  parameter int TRAP_BASE = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  logic [2:0]       opKind,
  input  logic [TRAPW-1:0] trapNum,
  input  logic             excReq,
  input  logic             excFull,
  input  logic [VECW-1:0]  excVector,
  input  logic             a7WrEn,
  input  logic             sBit,
  input  logic             frameAvail,
  input  logic             topFull,
  output ctrlStrobe_t      strb,
  output logic             busy,
  output logic             inEntry,
  output logic             opGrant,
  output logic             privViol,
  output logic             flush,
  output logic             excTaken,
  output logic [VECW-1:0]  vectorOut
);

  seqState_e stateQ, stateD;
  logic entryFullQ;
  logic grantD, violD, flushD, takenD;
  logic startEntry, entryFullD;
  logic [VECW-1:0] entryVec, vectorQ;
  opKind_e kind;

  assign kind = opKind_e'(opKind);

  always_comb begin
    strb       = '0;
    stateD     = stateQ;
    grantD     = 1'b0;
    violD      = 1'b0;
    flushD     = 1'b0;
    takenD     = 1'b0;
    startEntry = 1'b0;
    entryFullD = 1'b0;
    entryVec   = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (excReq) begin
          startEntry = 1'b1;
          entryVec   = excVector;
          entryFullD = excFull;
        end else if (opValid) begin
          case (kind)
            OP_PLAIN: grantD = 1'b1;
            OP_STOP, OP_LPSTOP, OP_RESET: begin
              if (sBit) grantD = 1'b1;
              else      violD  = 1'b1;
            end
            OP_SRWR: begin
              if (sBit) begin
                grantD      = 1'b1;
                flushD      = 1'b1;
                strb.srLoad = 1'b1;
              end else begin
                violD = 1'b1;
              end
            end
            OP_TRAP: begin
              startEntry = 1'b1;
              entryVec   = VECW'(TRAP_BASE) + VECW'(trapNum);
            end
            OP_RTE: begin
              if (!sBit) begin
                violD = 1'b1;
              end else if (frameAvail) begin
                if (topFull) begin
                  stateD = ST_RTE_FULL;
                end else begin
                  strb.rteShort = 1'b1;
                  grantD        = 1'b1;
                  flushD        = 1'b1;
                end
              end
            end
            default: ;
          endcase
          if (violD) begin
            startEntry = 1'b1;
            entryVec   = VECW'(PRIV_VEC);
          end
        end
        if (startEntry) begin
          strb.latchEntry = 1'b1;
          strb.entryFull  = entryFullD;
          stateD          = ST_PUSH_SR;
        end else if (a7WrEn && !strb.rteShort && stateD == ST_IDLE) begin
          strb.a7Write = 1'b1;
        end
      end
      ST_PUSH_SR: begin
        strb.pushSr = 1'b1;
        stateD      = ST_PUSH_PC;
      end
      ST_PUSH_PC: begin
        strb.pushPc = 1'b1;
        if (entryFullQ) begin
          stateD = ST_PUSH_ST;
        end else begin
          strb.finishEntry = 1'b1;
          takenD           = 1'b1;
          stateD           = ST_IDLE;
        end
      end
      ST_PUSH_ST: begin
        strb.pushSt      = 1'b1;
        strb.finishEntry = 1'b1;
        takenD           = 1'b1;
        stateD           = ST_IDLE;
      end
      ST_RTE_FULL: begin
        strb.rteFull = 1'b1;
        grantD       = 1'b1;
        flushD       = 1'b1;
        stateD       = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ     <= ST_IDLE;
      entryFullQ <= 1'b0;
      vectorQ    <= '0;
      opGrant    <= 1'b0;
      privViol   <= 1'b0;
      flush      <= 1'b0;
      excTaken   <= 1'b0;
    end else begin
      stateQ   <= stateD;
      opGrant  <= grantD;
      privViol <= violD;
      flush    <= flushD;
      excTaken <= takenD;
      if (startEntry) begin
        entryFullQ <= entryFullD;
        vectorQ    <= entryVec;
      end
    end
  end

  assign vectorOut = vectorQ;
  assign busy      = (stateQ != ST_IDLE);
  assign inEntry   = (stateQ == ST_PUSH_SR) || (stateQ == ST_PUSH_PC) ||
                     (stateQ == ST_PUSH_ST);

  AST_VIOL_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    privViol |=> !privViol); // R6
  AST_VIOL_NO_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    privViol |-> !opGrant); // R6
  AST_VIOL_ENTERS: assert property (@(posedge clk) disable iff (!rstN)
    privViol |-> busy); // R6
  AST_S_RISE_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sBit) |-> (excTaken || flush)); // R8

endmodule

// File: rtl/privctl_dp.sv
module privctl_dp
  import privctl_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int SRW   = 16,
  parameter int SPOS  = 13,
  parameter int DEPTH = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrlStrobe_t     strb,
  input  logic            inEntry,
  input  logic [AW-1:0]   resetSsp,
  input  logic [SRW-1:0]  srWrData,
  input  logic [AW-1:0]   a7WrData,
  input  logic [AW-1:0]   pcIn,
  input  logic [DW-1:0]   stateIn,
  input  logic            busProg,
  input  logic            busCpu,
  output logic [SRW-1:0]  srOut,
  output logic            sBit,
  output logic [AW-1:0]   a7Out,
  output logic [2:0]      fcOut,
  output logic            frameAvail,
  output logic            topFull,
  output logic            pushValid,
  output logic [DW-1:0]   pushData,
  output logic            restoreValid,
  output logic [AW-1:0]   restorePc,
  output logic [DW-1:0]   restoreState,
  output logic            restoreFull
);

  localparam int IDXW        = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW        = $clog2(DEPTH + 1);
  localparam int SHORT_BYTES = (SRW + AW) / 8;
  localparam int FULL_BYTES  = SHORT_BYTES + DW / 8;
  localparam logic [SRW-1:0] SR_RESET = SRW'(1) << SPOS;

  logic [SRW-1:0]  srQ;
  logic [AW-1:0]   uspQ, sspQ;
  logic [CNTW-1:0] countQ;
  logic [SRW-1:0]  savedSr;
  logic [AW-1:0]   savedPc;
  logic [DW-1:0]   savedSt;
  logic            savedFull;
  logic [IDXW-1:0] wrIdx, topIdx;

  logic [SRW-1:0] slotSr  [DEPTH];
  logic [AW-1:0]  slotPc  [DEPTH];
  logic [DW-1:0]  slotSt  [DEPTH];
  logic           slotTag [DEPTH];

  logic [SRW-1:0] topSr;
  logic [AW-1:0]  topPc;
  logic [DW-1:0]  topSt;
  logic [AW-1:0]  topBytes;
  logic           rteAny, superEff;

  assign wrIdx  = (countQ >= CNTW'(DEPTH)) ? IDXW'(DEPTH - 1) : IDXW'(countQ);
  assign topIdx = IDXW'(countQ - CNTW'(1));

  // One frame slot per nesting level
  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    logic [SRW-1:0] srS;
    logic [AW-1:0]  pcS;
    logic [DW-1:0]  stS;
    logic           tagS;
    logic           sel;
    assign sel = (wrIdx == IDXW'(g));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        srS  <= '0;
        pcS  <= '0;
        stS  <= '0;
        tagS <= 1'b0;
      end else if (sel) begin
        if (strb.pushSr) srS <= savedSr;
        if (strb.pushPc) begin
          pcS  <= savedPc;
          tagS <= savedFull;
        end
        if (strb.pushSt) stS <= savedSt;
      end
    end
    assign slotSr[g]  = srS;
    assign slotPc[g]  = pcS;
    assign slotSt[g]  = stS;
    assign slotTag[g] = tagS;
  end

  assign topSr      = slotSr[topIdx];
  assign topPc      = slotPc[topIdx];
  assign topSt      = slotSt[topIdx];
  assign topFull    = slotTag[topIdx];
  assign topBytes   = topFull ? AW'(FULL_BYTES) : AW'(SHORT_BYTES);
  assign frameAvail = (countQ != '0);
  assign rteAny     = strb.rteShort || strb.rteFull;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srQ          <= SR_RESET;
      uspQ         <= '0;
      sspQ         <= resetSsp;
      countQ       <= '0;
      savedSr      <= '0;
      savedPc      <= '0;
      savedSt      <= '0;
      savedFull    <= 1'b0;
      pushValid    <= 1'b0;
      pushData     <= '0;
      restoreValid <= 1'b0;
      restorePc    <= '0;
      restoreState <= '0;
      restoreFull  <= 1'b0;
    end else begin
      pushValid    <= 1'b0;
      restoreValid <= 1'b0;
      if (strb.latchEntry) begin
        savedSr   <= srQ;
        savedPc   <= pcIn;
        savedSt   <= stateIn;
        savedFull <= strb.entryFull;
      end
      if (strb.pushSr) begin
        pushValid <= 1'b1;
        pushData  <= DW'(savedSr);
      end
      if (strb.pushPc) begin
        pushValid <= 1'b1;
        pushData  <= DW'(savedPc);
      end
      if (strb.pushSt) begin
        pushValid <= 1'b1;
        pushData  <= savedSt;
      end
      if (strb.finishEntry) begin
        srQ[SPOS] <= 1'b1;
        sspQ      <= sspQ - (savedFull ? AW'(FULL_BYTES) : AW'(SHORT_BYTES));
        if (countQ < CNTW'(DEPTH)) countQ <= countQ + CNTW'(1);
      end
      if (strb.srLoad) srQ <= srWrData;
      if (rteAny) begin
        srQ          <= topSr;
        sspQ         <= sspQ + topBytes;
        countQ       <= countQ - CNTW'(1);
        restoreValid <= 1'b1;
        restorePc    <= topPc;
        restoreState <= strb.rteFull ? topSt : '0;
        restoreFull  <= strb.rteFull;
      end
      if (strb.a7Write) begin
        if (srQ[SPOS]) sspQ <= a7WrData;
        else           uspQ <= a7WrData;
      end
    end
  end

  assign srOut    = srQ;
  assign sBit     = srQ[SPOS];
  assign a7Out    = srQ[SPOS] ? sspQ : uspQ;
  assign superEff = srQ[SPOS] || inEntry;

  always_comb begin
    if (busCpu)        fcOut = FC_CPU;
    else if (superEff) fcOut = busProg ? FC_SUP_PROG : FC_SUP_DATA;
    else               fcOut = busProg ? FC_USR_PROG : FC_USR_DATA;
  end

  AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    countQ <= CNTW'(DEPTH)); // R9
  AST_PUSH_SUPER_FC: assert property (@(posedge clk) disable iff (!rstN)
    (pushValid && !busProg && !busCpu) |-> (fcOut == FC_SUP_DATA)); // R8

endmodule

// File: rtl/priv_exc_ctrl.sv
module priv_exc_ctrl
  import privctl_pkg::*;
#(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int SRW       = 16,
  parameter int SPOS      = 13,
  parameter int DEPTH     = 4,
  parameter int TRAPW     = 4,
  parameter int VECW      = 8,
  parameter int PRIV_VEC  = 8,
  parameter int TRAP_BASE = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [AW-1:0]    resetSsp,
  input  logic             opValid,
  input  logic [2:0]       opKind,
  input  logic [TRAPW-1:0] trapNum,
  input  logic [SRW-1:0]   srWrData,
  input  logic             excReq,
  input  logic             excFull,
  input  logic [VECW-1:0]  excVector,
  input  logic [AW-1:0]    pcIn,
  input  logic [DW-1:0]    stateIn,
  input  logic             a7WrEn,
  input  logic [AW-1:0]    a7WrData,
  input  logic             busProg,
  input  logic             busCpu,
  output logic [SRW-1:0]   srOut,
  output logic             sBit,
  output logic [AW-1:0]    a7Out,
  output logic [2:0]       fcOut,
  output logic             busy,
  output logic             opGrant,
  output logic             privViol,
  output logic             flush,
  output logic             excTaken,
  output logic [VECW-1:0]  vectorOut,
  output logic             pushValid,
  output logic [DW-1:0]    pushData,
  output logic             restoreValid,
  output logic [AW-1:0]    restorePc,
  output logic [DW-1:0]    restoreState,
  output logic             restoreFull
);

  ctrlStrobe_t strb;
  logic inEntry, frameAvail, topFull;

  privctl_seq #(
    .TRAPW(TRAPW), .VECW(VECW), .PRIV_VEC(PRIV_VEC), .TRAP_BASE(TRAP_BASE)
  ) seq_i (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opKind(opKind),
    .trapNum(trapNum), .excReq(excReq), .excFull(excFull),
    .excVector(excVector), .a7WrEn(a7WrEn), .sBit(sBit),
    .frameAvail(frameAvail), .topFull(topFull), .strb(strb), .busy(busy),
    .inEntry(inEntry), .opGrant(opGrant), .privViol(privViol),
    .flush(flush), .excTaken(excTaken), .vectorOut(vectorOut)
  );

  privctl_dp #(
    .AW(AW), .DW(DW), .SRW(SRW), .SPOS(SPOS), .DEPTH(DEPTH)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .inEntry(inEntry),
    .resetSsp(resetSsp), .srWrData(srWrData), .a7WrData(a7WrData),
    .pcIn(pcIn), .stateIn(stateIn), .busProg(busProg), .busCpu(busCpu),
    .srOut(srOut), .sBit(sBit), .a7Out(a7Out), .fcOut(fcOut),
    .frameAvail(frameAvail), .topFull(topFull), .pushValid(pushValid),
    .pushData(pushData), .restoreValid(restoreValid),
    .restorePc(restorePc), .restoreState(restoreState),
    .restoreFull(restoreFull)
  );

endmodule

// File: tb/priv_exc_ctrl_tb_top.sv
`timescale 1ns/100ps
module priv_exc_ctrl_tb_top;

  localparam logic [2:0] K_PLAIN = 3'd0, K_STOP = 3'd1, K_LPSTOP = 3'd2,
                         K_RESET = 3'd3, K_SRWR = 3'd4, K_TRAP = 3'd5,
                         K_RTE = 3'd6;

  // {super, busProg, busCpu, expected fc}
  localparam logic [5:0] FC_TAB [8] = '{
    {3'b100, 3'b101}, {3'b110, 3'b110}, {3'b101, 3'b111}, {3'b111, 3'b111},
    {3'b000, 3'b001}, {3'b010, 3'b010}, {3'b001, 3'b111}, {3'b011, 3'b111}
  };
  // {trap number, pc}
  localparam logic [35:0] TRAP_TAB [4] = '{
    {4'd0, 32'h0000_0100}, {4'd15, 32'h0000_2468},
    {4'd7, 32'h0000_00A0}, {4'd3, 32'h0000_FFFC}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [31:0] resetSsp = 32'h0000_1000;
  logic opValid = 1'b0;
  logic [2:0] opKind = 3'd0;
  logic [3:0] trapNum = 4'd0;
  logic [15:0] srWrData = 16'h0;
  logic excReq = 1'b0, excFull = 1'b0;
  logic [7:0] excVector = 8'd0;
  logic [31:0] pcIn = 32'h0, stateIn = 32'h0;
  logic a7WrEn = 1'b0;
  logic [31:0] a7WrData = 32'h0;
  logic busProg = 1'b0, busCpu = 1'b0;
  logic [15:0] srOut;
  logic sBit, busy, opGrant, privViol, flush, excTaken;
  logic [31:0] a7Out, pushData, restorePc, restoreState;
  logic [2:0] fcOut;
  logic [7:0] vectorOut;
  logic pushValid, restoreValid, restoreFull;

  int nChk = 0, nBad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  priv_exc_ctrl dut_i (
    .clk(clk), .rstN(rstN), .resetSsp(resetSsp), .opValid(opValid),
    .opKind(opKind), .trapNum(trapNum), .srWrData(srWrData),
    .excReq(excReq), .excFull(excFull), .excVector(excVector),
    .pcIn(pcIn), .stateIn(stateIn), .a7WrEn(a7WrEn), .a7WrData(a7WrData),
    .busProg(busProg), .busCpu(busCpu), .srOut(srOut), .sBit(sBit),
    .a7Out(a7Out), .fcOut(fcOut), .busy(busy), .opGrant(opGrant),
    .privViol(privViol), .flush(flush), .excTaken(excTaken),
    .vectorOut(vectorOut), .pushValid(pushValid), .pushData(pushData),
    .restoreValid(restoreValid), .restorePc(restorePc),
    .restoreState(restoreState), .restoreFull(restoreFull)
  );

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic issue(input logic [2:0] k);
    opValid = 1'b1;
    opKind  = k;
    cyc();
    opValid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChk++;
      nBad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    rstN = 1'b1;
    cyc();
    // R1 reset state
    chk("R1 srOut", srOut, 16'h2000);
    chk("R1 sBit", sBit, 1'b1);
    chk("R1 a7Out", a7Out, 32'h1000);
    chk("R1 busy", busy, 1'b0);

    // R12 return with empty frame store
    issue(K_RTE);
    chk("R12 no grant", opGrant, 1'b0);
    chk("R12 no flush", flush, 1'b0);
    chk("R12 no restore", restoreValid, 1'b0);
    chk("R12 sr kept", srOut, 16'h2000);
    chk("R12 busy", busy, 1'b0);

    // R2 supervisor A7 write
    a7WrEn = 1'b1; a7WrData = 32'h2000;
    cyc();
    a7WrEn = 1'b0;
    chk("R2 a7 super", a7Out, 32'h2000);

    // R4 plain, R5 privileged at supervisor
    issue(K_PLAIN);
    chk("R4 grant super", opGrant, 1'b1);
    chk("R4 sr kept", srOut, 16'h2000);
    for (int k = 1; k <= 3; k++) begin
      issue(3'(k));
      chk("R5 priv grant", opGrant, 1'b1);
      chk("R5 no viol", privViol, 1'b0);
    end

    // R3 function codes at both levels (switch to user midway)
    for (int i = 0; i < 8; i++) begin
      if (!FC_TAB[i][5] && sBit) begin
        srWrData = 16'h0015;
        issue(K_SRWR);
        chk("R5 sr loaded", srOut, 16'h0015);
        chk("R5 level user", sBit, 1'b0);
        chk("R5 flush", flush, 1'b1);
        chk("R5 grant", opGrant, 1'b1);
        chk("R1 usp cleared", a7Out, 32'h0);
      end
      busProg = FC_TAB[i][4];
      busCpu  = FC_TAB[i][3];
      #1;
      chk("R3 fc", fcOut, FC_TAB[i][2:0]);
      cyc();
    end
    busProg = 1'b0; busCpu = 1'b0;

    // R2 user A7 write, R4 plain at user
    a7WrEn = 1'b1; a7WrData = 32'h3000;
    cyc();
    a7WrEn = 1'b0;
    chk("R2 a7 user", a7Out, 32'h3000);
    issue(K_PLAIN);
    chk("R4 grant user", opGrant, 1'b1);

    // R6 stop at user level, R8 entry order, R13 busy
    pcIn = 32'h400;
    issue(K_STOP);
    chk("R6 viol", privViol, 1'b1);
    chk("R6 no grant", opGrant, 1'b0);
    chk("R6 sr kept", srOut, 16'h0015);
    chk("R6 busy", busy, 1'b1);
    opValid = 1'b1; opKind = K_PLAIN;
    #1;
    chk("R8 entry fc", fcOut, 3'b101);
    cyc();
    opValid = 1'b0;
    chk("R13 ignored", opGrant, 1'b0);
    chk("R6 viol pulse", privViol, 1'b0);
    chk("R8 push sr", pushValid, 1'b1);
    chk("R8 sr word", pushData, 32'h0015);
    chk("R8 still user", sBit, 1'b0);
    cyc();
    chk("R8 push pc", pushData, 32'h400);
    chk("R8 super", sBit, 1'b1);
    chk("R8 taken", excTaken, 1'b1);
    chk("R6 vector", vectorOut, 8'd8);
    chk("R9 ssp short", a7Out, 32'h1FFA);
    chk("R13 idle", busy, 1'b0);

    // R10 short return
    issue(K_RTE);
    chk("R10 restore", restoreValid, 1'b1);
    chk("R10 pc", restorePc, 32'h400);
    chk("R10 short", restoreFull, 1'b0);
    chk("R10 sr", srOut, 16'h0015);
    chk("R10 level", sBit, 1'b0);
    chk("R10 flush", flush, 1'b1);
    chk("R2 usp kept", a7Out, 32'h3000);

    // R7 traps
    for (int i = 0; i < 4; i++) begin
      trapNum = TRAP_TAB[i][35:32];
      pcIn    = TRAP_TAB[i][31:0];
      issue(K_TRAP);
      chk("R7 no viol", privViol, 1'b0);
      chk("R7 busy", busy, 1'b1);
      cyc();
      cyc();
      chk("R7 taken", excTaken, 1'b1);
      chk("R7 vector", vectorOut, 8'(32 + int'(TRAP_TAB[i][35:32])));
      chk("R9 ssp back", a7Out, 32'h1FFA);
      issue(K_RTE);
      chk("R10 trap pc", restorePc, TRAP_TAB[i][31:0]);
      chk("R10 trap level", sBit, 1'b0);
    end

    // R6 status write at user level
    srWrData = 16'h2000;
    issue(K_SRWR);
    chk("R6 srwr viol", privViol, 1'b1);
    chk("R6 srwr kept", srOut, 16'h0015);
    cyc(); cyc();
    chk("R6 srwr vector", vectorOut, 8'd8);
    issue(K_RTE);

    // R12 return at user level
    issue(K_RTE);
    chk("R12 user viol", privViol, 1'b1);
    chk("R12 user no restore", restoreValid, 1'b0);
    cyc(); cyc();
    issue(K_RTE);
    chk("R10 back user", srOut, 16'h0015);

    // R14 external full-frame exception, R11 full return
    pcIn = 32'h800; stateIn = 32'hDEAD_BEEF;
    excReq = 1'b1; excFull = 1'b1; excVector = 8'd2;
    cyc();
    excReq = 1'b0; excFull = 1'b0;
    chk("R14 busy", busy, 1'b1);
    cyc();
    chk("R8 full sr", pushData, 32'h0015);
    cyc();
    chk("R8 full pc", pushData, 32'h800);
    chk("R8 full not yet", sBit, 1'b0);
    cyc();
    chk("R14 state push", pushData, 32'hDEAD_BEEF);
    chk("R14 super", sBit, 1'b1);
    chk("R14 taken", excTaken, 1'b1);
    chk("R14 vector", vectorOut, 8'd2);
    chk("R9 ssp full", a7Out, 32'h1FF6);
    issue(K_RTE);
    chk("R11 first cycle", restoreValid, 1'b0);
    chk("R11 busy", busy, 1'b1);
    cyc();
    chk("R11 restore", restoreValid, 1'b1);
    chk("R11 full", restoreFull, 1'b1);
    chk("R11 state", restoreState, 32'hDEAD_BEEF);
    chk("R11 pc", restorePc, 32'h800);
    chk("R11 level", sBit, 1'b0);
    chk("R11 flush", flush, 1'b1);
    chk("R11 grant", opGrant, 1'b1);
    chk("R2 usp final", a7Out, 32'h3000);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule